// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between four external interrupt request pins and the downstream priority logic of an interrupt controller. Every pin is first brought into the core clock domain by a short synchroniser chain. A per-pin two-bit sense code then chooses how the synchronised pin is read.

- Two of the codes are level modes, one active-high and one active-low. In a level mode the request follows the pin directly, with nothing latched.
- The other two codes are edge modes, one rising and one falling. In an edge mode the chosen edge sets a sticky latch, which holds until software clears it.

The four pins share one 32-bit control word. Software writes this word and reads it back with a single-cycle write strobe. The word holds:

- the sense codes;
- a per-pin enable;
- a write-one-to-clear bit per pin, which always reads back as zero;
- a master enable for all external pins;
- a bit that selects normal routing of the critical request, which sits at 1 after reset.

A pin's request reaches the priority logic only when the pin's own enable and the master enable are both set. A software initialisation step typically does the following in one write:

- keeps the sense codes;
- clears all four latches;
- sets the master enable;
- leaves every pin disabled.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset the control word reads 0x00000001, and all four requests are 0.
- R2: Only these bits are held and read back: the sense codes at [23-2n:22-2n], the pin enables at 11-n, the master enable at 12 and the route bit at 0. Every other bit reads 0, and the clear bits [27:24] always read 0. A write takes effect on the next read.
- R3: With sense code 0 (active-high level), pin n's request equals the pin value delayed by the two-flop synchroniser, and nothing is latched.
- R4: With sense code 3 (active-low level), pin n's request is the inverse of the synchronised pin.
- R5: With sense code 1 (rising edge), a rising edge sets a latch. The latch shows on the request one cycle after the synchronised edge and stays set after the pin falls.
- R6: With sense code 2 (falling edge), a falling edge sets the latch, and the latch stays set after the pin rises again.
- R7: Writing 1 to control bit 27-n clears the latch of pin n only.
- R8: When a clear of pin n and a new edge of pin n land in the same cycle, the clear wins and the latch stays 0.
- R9: Pin n raises a request only while its enable bit 11-n is 1.
- R10: No pin raises a request while the master enable bit 12 is 0.
- R11: An edge latch is set even while the pin or master enable is 0. The latch shows on the request once the enables are set.
- R12: The route output `crit_route_o` equals control bit 0, and this bit is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Single-cycle write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| irq_pin_i | input | NUM_PINS | Asynchronous external request pins |
| irq_req_o | output | NUM_PINS | Qualified request per pin, sent to the priority logic |
| crit_route_o | output | 1 | Normal routing selected for the critical request |

## Verification
The bench builds the block with its defaults, four pins and a two-stage synchroniser. At these values the bit positions 27-n, 23-2n and 11-n are all fixed. This brings every pin's field layout within reach, and the exact synchroniser latency can be counted for both level modes and both edge modes. Directed tests place a clear write in the very cycle a synchronised edge appears, to show that the clear wins. They also toggle the enables over latches that are already set, to show that the enables gate the requests without altering the latches.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int CTRL_W     = 32;
  localparam int MAX_PINS   = 4;
  localparam int MASTER_POS = 12;
  localparam int ROUTE_POS  = 0;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 32'h0000_0001;

  typedef enum logic [1:0] {
    SENSE_LVL_HI = 2'd0,
    SENSE_RISE   = 2'd1,
    SENSE_FALL   = 2'd2,
    SENSE_LVL_LO = 2'd3
  } sense_e;

  // Field placement inside the control word; the layout is decoded by software.
  function automatic int sense_pos(input int n);
    return 22 - 2 * n;
  endfunction

  function automatic int enable_pos(input int n);
    return 11 - n;
  endfunction

  function automatic int clear_pos(input int n);
    return 27 - n;
  endfunction

  function automatic logic [CTRL_W-1:0] writable_mask(input int npins);
    logic [CTRL_W-1:0] m;
    m = '0;
    m[MASTER_POS] = 1'b1;
    m[ROUTE_POS]  = 1'b1;
    for (int i = 0; i < npins; i++) begin
      m[sense_pos(i) +: 2] = 2'b11;
      m[enable_pos(i)]     = 1'b1;
    end
    return m;
  endfunction

  function automatic logic sense_is_edge(input logic [1:0] mode);
    return (mode == SENSE_RISE) || (mode == SENSE_FALL);
  endfunction

  function automatic logic edge_seen(input logic [1:0] mode, input logic cur,
                                     input logic prv);
    logic hit;
    hit = 1'b0;
    if (mode == SENSE_RISE)      hit = cur & ~prv;
    else if (mode == SENSE_FALL) hit = ~cur & prv;
    return hit;
  endfunction

  function automatic logic level_seen(input logic [1:0] mode, input logic cur);
    logic hit;
    hit = 1'b0;
    if (mode == SENSE_LVL_HI)      hit = cur;
    else if (mode == SENSE_LVL_LO) hit = ~cur;
    return hit;
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/ext_irq_ctrl_reg.sv
module ext_irq_ctrl_reg
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CTRL_W-1:0]     wr_data,
  output logic [CTRL_W-1:0]     rd_data,
  output logic [2*NUM_PINS-1:0] sense_o,
  output logic [NUM_PINS-1:0]   enable_o,
  output logic [NUM_PINS-1:0]   clear_o,
  output logic                  master_o,
  output logic                  route_o
);

  localparam logic [CTRL_W-1:0] WR_MASK = writable_mask(NUM_PINS);

  logic [2*NUM_PINS-1:0] sense_q;
  logic [NUM_PINS-1:0]   en_q;
  logic                  master_q;
  logic                  route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q  <= '0;
      en_q     <= '0;
      master_q <= CTRL_RESET[MASTER_POS];
      route_q  <= CTRL_RESET[ROUTE_POS];
    end else if (wr_en) begin
      master_q <= wr_data[MASTER_POS];
      route_q  <= wr_data[ROUTE_POS];
      for (int i = 0; i < NUM_PINS; i++) begin
        sense_q[2*i +: 2] <= wr_data[sense_pos(i) +: 2];
        en_q[i]           <= wr_data[enable_pos(i)];
      end
    end
  end

  // Clear bits are strobes only: they act in the write cycle and are never stored.
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_clr
    assign clear_o[g] = wr_en & wr_data[clear_pos(g)];
  end

  always_comb begin
    rd_data             = '0;
    rd_data[MASTER_POS] = master_q;
    rd_data[ROUTE_POS]  = route_q;
    for (int i = 0; i < NUM_PINS; i++) begin
      rd_data[sense_pos(i) +: 2] = sense_q[2*i +: 2];
      rd_data[enable_pos(i)]     = en_q[i];
    end
  end

  assign sense_o  = sense_q;
  assign enable_o = en_q;
  assign master_o = master_q;
  assign route_o  = route_q;

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & WR_MASK));

endmodule

// File: rtl/ext_irq_pin.sv
module ext_irq_pin
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s_i,
  input  logic [1:0] sense_i,
  input  logic       enable_i,
  input  logic       master_i,
  input  logic       clear_i,
  output logic       req_o
);

  logic prev_q;
  logic latch_q;
  logic edge_hit;
  logic level_hit;
  logic source;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_s_i;
  end

  assign edge_hit  = edge_seen(sense_i, pin_s_i, prev_q);
  assign level_hit = level_seen(sense_i, pin_s_i);

  // Clear has priority over a coincident edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= 1'b0;
    else if (clear_i)  latch_q <= 1'b0;
    else if (edge_hit) latch_q <= 1'b1;
  end

  assign source = sense_is_edge(sense_i) ? latch_q : level_hit;
  assign req_o  = source & enable_i & master_i;

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !latch_q);

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q && !clear_i |=> latch_q);

  // R11
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit && !clear_i |=> latch_q);

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [CTRL_W-1:0]   reg_wdata,
  output logic [CTRL_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] irq_pin_i,
  output logic [NUM_PINS-1:0] irq_req_o,
  output logic                crit_route_o
);

  logic [NUM_PINS-1:0]   pin_sync;
  logic [2*NUM_PINS-1:0] sense;
  logic [NUM_PINS-1:0]   pin_en;
  logic [NUM_PINS-1:0]   pin_clr;
  logic                  master_en;

  ext_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (irq_pin_i),
    .q_o   (pin_sync)
  );

  ext_irq_ctrl_reg #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_we),
    .wr_data  (reg_wdata),
    .rd_data  (reg_rdata),
    .sense_o  (sense),
    .enable_o (pin_en),
    .clear_o  (pin_clr),
    .master_o (master_en),
    .route_o  (crit_route_o)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    ext_irq_pin u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_s_i  (pin_sync[g]),
      .sense_i  (sense[2*g +: 2]),
      .enable_i (pin_en[g]),
      .master_i (master_en),
      .clear_i  (pin_clr[g]),
      .req_o    (irq_req_o[g])
    );

    // R3
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense[2*g +: 2] == SENSE_LVL_HI) && pin_en[g] && master_en
        |-> irq_req_o[g] == pin_sync[g]);
  end

  // R10
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> irq_req_o == '0);

  // R9
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o & ~pin_en) == '0);

endmodule

// File: tb/ext_irq_cond_bench.sv
module ext_irq_cond_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  pin;
  logic [3:0]  req;
  logic        crit;

  int n_chk = 0;
  int n_bad = 0;

  logic [1:0] md [4];
  logic [3:0] en;
  logic       mst;
  logic       rte;

  always #5 clk = ~clk;

  ext_irq_cond u_ext_irq_cond (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (we),
    .reg_wdata    (wdata),
    .reg_rdata    (rdata),
    .irq_pin_i    (pin),
    .irq_req_o    (req),
    .crit_route_o (crit)
  );

  function automatic logic [31:0] cfg(input logic [3:0] clr);
    logic [31:0] w;
    w = '0;
    for (int p = 0; p < 4; p++) begin
      w[23-2*p -: 2] = md[p];
      w[11-p]        = en[p];
      w[27-p]        = clr[p];
    end
    w[12] = mst;
    w[0]  = rte;
    return w;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] w);
    we = 1'b1;
    wdata = w;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic fresh(input logic [3:0] p);
    pin = p;
    tick(3);
    md = '{default: 2'd0};
    en = 4'b0000;
    mst = 1'b1;
    rte = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic t_reset();
    chk(rdata, 32'h0000_0001, "R1 control word after reset");
    chk({28'b0, req}, 32'h0, "R1 requests after reset");
    chk({31'b0, crit}, 32'h1, "R12 route bit after reset");
  endtask

  task automatic t_regs();
    wr(32'hFFFF_FFFF);
    chk(rdata, 32'h00FF_1F01, "R2 writable mask readback");
    chk({31'b0, crit}, 32'h1, "R12 route set");
    wr(32'h0000_0000);
    chk(rdata, 32'h0, "R2 all-zero readback");
    chk({31'b0, crit}, 32'h0, "R12 route cleared");
    wr(32'h00A5_0000);
    wr((rdata & 32'h00FF_0000) | 32'h0F00_1001);
    chk(rdata, 32'h00A5_1001, "R2 initialisation write");
  endtask

  task automatic t_level_hi();
    fresh(4'b0000);
    en = 4'b0001;
    wr(cfg(4'hF));
    chk({28'b0, req}, 32'h0, "R3 pin low");
    pin[0] = 1'b1;
    tick(1);
    chk({28'b0, req}, 32'h0, "R3 one stage in");
    tick(1);
    chk({28'b0, req}, 32'h1, "R3 after two stages");
    pin[0] = 1'b0;
    tick(2);
    chk({28'b0, req}, 32'h0, "R3 follows pin low");
  endtask

  task automatic t_level_lo();
    fresh(4'b0010);
    md[1] = 2'd3;
    en = 4'b0010;
    wr(cfg(4'hF));
    chk({28'b0, req}, 32'h0, "R4 pin high inactive");
    pin[1] = 1'b0;
    tick(1);
    chk({28'b0, req}, 32'h0, "R4 one stage in");
    tick(1);
    chk({28'b0, req}, 32'h2, "R4 pin low active");
  endtask

  task automatic t_rise();
    fresh(4'b0000);
    md[2] = 2'd1;
    en = 4'b0100;
    wr(cfg(4'hF));
    chk({28'b0, req}, 32'h0, "R5 idle");
    pin[2] = 1'b1;
    tick(2);
    chk({28'b0, req}, 32'h0, "R5 edge not latched yet");
    tick(1);
    chk({28'b0, req}, 32'h4, "R5 rising edge latched");
    pin[2] = 1'b0;
    tick(4);
    chk({28'b0, req}, 32'h4, "R5 latch sticky");
    wr(cfg(4'b0100));
    chk({28'b0, req}, 32'h0, "R7 bit 25 clears pin 2");
  endtask

  task automatic t_fall();
    fresh(4'b1000);
    md[3] = 2'd2;
    en = 4'b1000;
    wr(cfg(4'hF));
    chk({28'b0, req}, 32'h0, "R6 idle high");
    pin[3] = 1'b0;
    tick(2);
    chk({28'b0, req}, 32'h0, "R6 edge not latched yet");
    tick(1);
    chk({28'b0, req}, 32'h8, "R6 falling edge latched");
    pin[3] = 1'b1;
    tick(3);
    chk({28'b0, req}, 32'h8, "R6 latch sticky");
  endtask

  task automatic t_sel_clear();
    fresh(4'b0000);
    md[2] = 2'd1;
    md[3] = 2'd1;
    en = 4'b1100;
    wr(cfg(4'hF));
    pin = 4'b1100;
    tick(3);
    chk({28'b0, req}, 32'hC, "R7 both latched");
    wr(cfg(4'b0100));
    chk({28'b0, req}, 32'h8, "R7 only pin 2 cleared");
    wr(cfg(4'b1000));
    chk({28'b0, req}, 32'h0, "R7 bit 24 clears pin 3");
  endtask

  task automatic t_clear_wins();
    fresh(4'b0000);
    md[0] = 2'd1;
    en = 4'b0001;
    wr(cfg(4'hF));
    pin[0] = 1'b1;
    tick(2);
    we = 1'b1;
    wdata = cfg(4'b0001);
    @(negedge clk);
    we = 1'b0;
    chk({28'b0, req}, 32'h0, "R8 clear wins same cycle");
    tick(3);
    chk({28'b0, req}, 32'h0, "R8 edge stays consumed");
  endtask

  task automatic t_enable();
    fresh(4'b0000);
    md = '{default: 2'd1};
    en = 4'b1111;
    wr(cfg(4'hF));
    pin = 4'b1111;
    tick(3);
    chk({28'b0, req}, 32'hF, "R9 all latched and enabled");
    en = 4'b1010;
    wr(cfg(4'h0));
    chk({28'b0, req}, 32'hA, "R9 per-pin enable gates");
    en = 4'b1111;
    wr(cfg(4'h0));
    chk({28'b0, req}, 32'hF, "R9 latches kept under disable");
    mst = 1'b0;
    wr(cfg(4'h0));
    chk({28'b0, req}, 32'h0, "R10 master off");
    chk({31'b0, rdata[12]}, 32'h0, "R10 master bit reads 0");
    mst = 1'b1;
    wr(cfg(4'h0));
    chk({28'b0, req}, 32'hF, "R10 master on");
  endtask

  task automatic t_hidden_latch();
    fresh(4'b0000);
    md[1] = 2'd1;
    mst = 1'b0;
    wr(cfg(4'hF));
    pin[1] = 1'b1;
    tick(4);
    chk({28'b0, req}, 32'h0, "R11 latch hidden while disabled");
    en = 4'b0010;
    mst = 1'b1;
    wr(cfg(4'h0));
    chk({28'b0, req}, 32'h2, "R11 latch shows on enable");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    we = 1'b0;
    wdata = '0;
    pin = '0;
    md = '{default: 2'd0};
    en = '0;
    mst = 1'b0;
    rte = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_level_hi();
    t_level_lo();
    t_rise();
    t_fall();
    t_sel_clear();
    t_clear_wins();
    t_enable();
    t_hidden_latch();
    summary();
    $finish;
  end

endmodule